// File: doc/BRIEF.md
# In-Order Three-Way Issue Queue Dispatch Arbiter

This block sits between an in-order instruction queue and three issue queues, one each for floating-point, vector and general instructions. In every cycle it looks at the three oldest instruction-queue entries. It decides, in program order, which of them leave the instruction queue in that cycle, and it names the issue queue that each one goes to.

An instruction leaves only if all of the following hold:

- Its target queue has not yet reached its per-cycle acceptance limit.
- Its target queue reports a free entry.
- A completion-queue entry is free.
- Every older head slot is also leaving in this cycle.

Instructions whose class needs no issue queue still take a completion-queue entry.

The block has no state. The grants, the target selects and the dispatch count are a combinational function of the head-slot tags and the free counts reported by the queues. The instruction queue uses the dispatch count to pop that many entries at the next clock edge.

Top module: `dq_dispatch_arb`

## Requirements
- R1: Only the three head slots take part, and the dispatch count `disp_cnt` never exceeds three. With every slot invalid, all grants, target selects and the count are zero.
- R2: Grants are strictly in order. When slot N is not granted, no slot younger than N is granted in the same cycle.
- R3: A head slot whose valid bit is low is not granted, and no younger slot is granted either.
- R4: At most one instruction of class 1 (floating point) is granted per cycle.
- R5: At most two instructions of class 2 (vector) are granted per cycle.
- R6: Up to three instructions of class 3 (general) are granted in one cycle.
- R7: For classes 1, 2 and 3, the number granted to a queue never exceeds the free count that queue reports.
- R8: The total number granted never exceeds `cq_free`. This includes class 0 instructions, which need no issue-queue entry.
- R9: The 2-bit field `slot_tgt[2i+1:2i]` of a granted slot i equals that slot's class tag. The class tags are 0 for no queue, 1 for floating point, 2 for vector and 3 for general. For a slot that is not granted, the field is 0.
- R10: `disp_cnt` equals the number of set bits in `slot_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| head_vld | input | 3 | Valid bit per head slot; bit 0 is the oldest |
| head_cls | input | 6 | Class tag per head slot; bits [2i+1:2i] belong to slot i |
| fp_free | input | 4 | Free entries in the floating-point issue queue |
| vec_free | input | 4 | Free entries in the vector issue queue |
| gen_free | input | 4 | Free entries in the general issue queue |
| cq_free | input | 5 | Free entries in the completion queue |
| slot_go | output | 3 | Dispatch grant per head slot |
| slot_tgt | output | 6 | Target issue queue per slot; bits [2i+1:2i] belong to slot i |
| disp_cnt | output | 2 | Number of granted slots, used to pop the instruction queue |

## Verification
Every output depends only on the present inputs through combinational logic, so each result is due in the same cycle as its stimulus, and no register lies on any path. The bench therefore drives a new input set just after a rising edge and compares all outputs against its behavioural model at the following falling edge. This gives the logic half a period to settle and keeps every check clear of the edge. Directed cases for each class limit, each free-count limit and invalid slots run first, followed by a long randomised stretch that is weighted toward small free counts.

// File: rtl/dq_pkg.sv
package dq_pkg;

  // Class tag carried by each instruction-queue head entry.
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_FP   = 2'd1,
    CLS_VEC  = 2'd2,
    CLS_GEN  = 2'd3
  } iclass_e;

  localparam int unsigned NCLS  = 4;
  localparam int unsigned CLS_W = 2;

endpackage

// File: rtl/dq_room.sv
// Per-cycle room for one resource: the smaller of the reported free count
// and the static acceptance limit.
module dq_room #(
  parameter int unsigned FREE_W = 4,
  parameter int unsigned LIMIT  = 1,
  parameter int unsigned OUT_W  = 2
) (
  input  logic [FREE_W-1:0] free_cnt,
  output logic [OUT_W-1:0]  room
);

  always_comb begin
    if (32'(free_cnt) > LIMIT) begin
      room = OUT_W'(LIMIT);
    end else begin
      room = OUT_W'(free_cnt);
    end
  end

endmodule

// File: rtl/dq_slot.sv
// One link of the in-order dispatch chain: decides a single head slot from
// the usage already claimed by older slots.
module dq_slot
  import dq_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic                        chain_ok,
  input  logic                        vld,
  input  iclass_e                     cls,
  input  logic [NCLS-1:0][CNT_W-1:0]  used_in,
  input  logic [NCLS-1:0][CNT_W-1:0]  room,
  input  logic [CNT_W-1:0]            cq_used_in,
  input  logic [CNT_W-1:0]            cq_room,
  output logic                        go,
  output logic [NCLS-1:0][CNT_W-1:0]  used_out,
  output logic [CNT_W-1:0]            cq_used_out
);

  logic q_space;
  logic cq_space;

  always_comb begin
    q_space  = used_in[cls] < room[cls];
    cq_space = cq_used_in < cq_room;
    go       = chain_ok & vld & q_space & cq_space;

    used_out = used_in;
    if (go) begin
      used_out[cls] = used_in[cls] + CNT_W'(1);
    end
    cq_used_out = cq_used_in + CNT_W'(go);
  end

endmodule

// File: rtl/dq_dispatch_arb.sv
module dq_dispatch_arb
  import dq_pkg::*;
#(
  parameter int unsigned SLOTS   = 3,
  parameter int unsigned FREE_W  = 4,
  parameter int unsigned CQ_W    = 5,
  parameter int unsigned FP_LIM  = 1,
  parameter int unsigned VEC_LIM = 2,
  parameter int unsigned GEN_LIM = 3,
  parameter int unsigned CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]       head_vld,
  input  logic [CLS_W*SLOTS-1:0] head_cls,
  input  logic [FREE_W-1:0]      fp_free,
  input  logic [FREE_W-1:0]      vec_free,
  input  logic [FREE_W-1:0]      gen_free,
  input  logic [CQ_W-1:0]        cq_free,
  output logic [SLOTS-1:0]       slot_go,
  output logic [CLS_W*SLOTS-1:0] slot_tgt,
  output logic [CNT_W-1:0]       disp_cnt
);

  // Limits above the slot count can never bind; clamp so rooms fit CNT_W.
  localparam int unsigned FP_EFF  = (FP_LIM  < SLOTS) ? FP_LIM  : SLOTS;
  localparam int unsigned VEC_EFF = (VEC_LIM < SLOTS) ? VEC_LIM : SLOTS;
  localparam int unsigned GEN_EFF = (GEN_LIM < SLOTS) ? GEN_LIM : SLOTS;

  logic [NCLS-1:0][CNT_W-1:0] room;
  logic [CNT_W-1:0]           cq_room;
  logic [CNT_W-1:0]           fp_room;
  logic [CNT_W-1:0]           vec_room;
  logic [CNT_W-1:0]           gen_room;

  dq_room #(.FREE_W(FREE_W), .LIMIT(FP_EFF),  .OUT_W(CNT_W)) u_room_fp  (.free_cnt(fp_free),  .room(fp_room));
  dq_room #(.FREE_W(FREE_W), .LIMIT(VEC_EFF), .OUT_W(CNT_W)) u_room_vec (.free_cnt(vec_free), .room(vec_room));
  dq_room #(.FREE_W(FREE_W), .LIMIT(GEN_EFF), .OUT_W(CNT_W)) u_room_gen (.free_cnt(gen_free), .room(gen_room));
  dq_room #(.FREE_W(CQ_W),   .LIMIT(SLOTS),   .OUT_W(CNT_W)) u_room_cq  (.free_cnt(cq_free),  .room(cq_room));

  always_comb begin
    room           = '0;
    room[CLS_NONE] = CNT_W'(SLOTS);
    room[CLS_FP]   = fp_room;
    room[CLS_VEC]  = vec_room;
    room[CLS_GEN]  = gen_room;
  end

  // Dispatch chain, oldest slot first.
  logic                       chain_ok [SLOTS+1];
  logic [NCLS-1:0][CNT_W-1:0] used     [SLOTS+1];
  logic [CNT_W-1:0]           cq_used  [SLOTS+1];

  assign chain_ok[0] = 1'b1;
  assign used[0]     = '0;
  assign cq_used[0]  = '0;

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    iclass_e cls_i;
    assign cls_i = iclass_e'(head_cls[CLS_W*gi +: CLS_W]);

    dq_slot #(.CNT_W(CNT_W)) u_slot (
      .chain_ok    (chain_ok[gi]),
      .vld         (head_vld[gi]),
      .cls         (cls_i),
      .used_in     (used[gi]),
      .room        (room),
      .cq_used_in  (cq_used[gi]),
      .cq_room     (cq_room),
      .go          (chain_ok[gi+1]),
      .used_out    (used[gi+1]),
      .cq_used_out (cq_used[gi+1])
    );

    assign slot_go[gi]                  = chain_ok[gi+1];
    assign slot_tgt[CLS_W*gi +: CLS_W]  = chain_ok[gi+1] ? cls_i : CLS_NONE;
  end

  assign disp_cnt = cq_used[SLOTS];

endmodule

// File: rtl/dq_dispatch_chk.sv
module dq_dispatch_chk
  import dq_pkg::*;
#(
  parameter int unsigned SLOTS   = 3,
  parameter int unsigned FREE_W  = 4,
  parameter int unsigned CQ_W    = 5,
  parameter int unsigned FP_LIM  = 1,
  parameter int unsigned VEC_LIM = 2,
  parameter int unsigned GEN_LIM = 3,
  parameter int unsigned CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]       head_vld,
  input  logic [CLS_W*SLOTS-1:0] head_cls,
  input  logic [FREE_W-1:0]      fp_free,
  input  logic [FREE_W-1:0]      vec_free,
  input  logic [FREE_W-1:0]      gen_free,
  input  logic [CQ_W-1:0]        cq_free,
  input  logic [SLOTS-1:0]       slot_go,
  input  logic [CLS_W*SLOTS-1:0] slot_tgt,
  input  logic [CNT_W-1:0]       disp_cnt
);

  always_comb begin
    automatic int n_fp  = 0;
    automatic int n_vec = 0;
    automatic int n_gen = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_go[i]) begin
        case (head_cls[CLS_W*i +: CLS_W])
          2'd1:    n_fp++;
          2'd2:    n_vec++;
          2'd3:    n_gen++;
          default: ;
        endcase
      end
    end

    p_cnt_bound_r1: assert (int'(disp_cnt) <= SLOTS);
    p_cnt_matches_r10: assert (int'(disp_cnt) == $countones(slot_go));
    p_fp_limit_r4: assert (n_fp <= FP_LIM);
    p_vec_limit_r5: assert (n_vec <= VEC_LIM);
    p_gen_limit_r6: assert (n_gen <= GEN_LIM);
    p_fp_space_r7: assert (n_fp <= int'(fp_free));
    p_vec_space_r7: assert (n_vec <= int'(vec_free));
    p_gen_space_r7: assert (n_gen <= int'(gen_free));
    p_cq_space_r8: assert ($countones(slot_go) <= int'(cq_free));

    for (int i = 0; i < SLOTS; i++) begin
      p_invalid_blocks_r3: assert (!slot_go[i] || head_vld[i]);
      if (i > 0) begin
        p_in_order_r2: assert (!slot_go[i] || slot_go[i-1]);
      end
      p_tgt_r9: assert (slot_go[i] ? (slot_tgt[CLS_W*i +: CLS_W] == head_cls[CLS_W*i +: CLS_W])
                                   : (slot_tgt[CLS_W*i +: CLS_W] == '0));
    end
  end

endmodule

bind dq_dispatch_arb dq_dispatch_chk #(
  .SLOTS(SLOTS), .FREE_W(FREE_W), .CQ_W(CQ_W),
  .FP_LIM(FP_LIM), .VEC_LIM(VEC_LIM), .GEN_LIM(GEN_LIM), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/test_dq_dispatch_arb.sv
`timescale 1ns/1ps
module test_dq_dispatch_arb;

  localparam time HALF = 10ns;   // 50 MHz

  logic       clk;
  logic       rst_n;
  logic [2:0] head_vld;
  logic [5:0] head_cls;
  logic [3:0] fp_free, vec_free, gen_free;
  logic [4:0] cq_free;
  logic [2:0] slot_go;
  logic [5:0] slot_tgt;
  logic [1:0] disp_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dq_dispatch_arb i_dq_dispatch_arb (
    .head_vld(head_vld), .head_cls(head_cls),
    .fp_free(fp_free), .vec_free(vec_free), .gen_free(gen_free),
    .cq_free(cq_free),
    .slot_go(slot_go), .slot_tgt(slot_tgt), .disp_cnt(disp_cnt)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  // Behavioural model: walk slots oldest first with per-queue tallies.
  task automatic model(output logic [2:0] eg, output logic [5:0] et, output int ec);
    int lim [4];
    int tally [4];
    int cq_taken;
    bit blocked;
    lim[0] = 3;
    lim[1] = (int'(fp_free)  < 1) ? int'(fp_free)  : 1;
    lim[2] = (int'(vec_free) < 2) ? int'(vec_free) : 2;
    lim[3] = (int'(gen_free) < 3) ? int'(gen_free) : 3;
    foreach (tally[k]) tally[k] = 0;
    cq_taken = 0;
    blocked  = 0;
    eg = '0; et = '0; ec = 0;
    for (int s = 0; s < 3; s++) begin
      int c;
      c = int'(head_cls[2*s +: 2]);
      if (!blocked && head_vld[s] && cq_taken < int'(cq_free) && tally[c] < lim[c]) begin
        eg[s] = 1'b1;
        et[2*s +: 2] = 2'(c);
        tally[c]++;
        cq_taken++;
        ec++;
      end else begin
        blocked = 1;
      end
    end
  endtask

  task automatic compare(string tag);
    logic [2:0] eg;
    logic [5:0] et;
    int ec;
    model(eg, et, ec);
    checks++;
    if (slot_go !== eg) begin
      errors++;
      $display("FAIL %s R2 slot_go actual %b expected %b", tag, slot_go, eg);
    end
    checks++;
    if (slot_tgt !== et) begin
      errors++;
      $display("FAIL %s R9 slot_tgt actual %h expected %h", tag, slot_tgt, et);
    end
    checks++;
    if (int'(disp_cnt) != ec) begin
      errors++;
      $display("FAIL %s R10 disp_cnt actual %0d expected %0d", tag, disp_cnt, ec);
    end
  endtask

  task automatic expect_go(string tag, logic [2:0] want);
    checks++;
    if (slot_go !== want) begin
      errors++;
      $display("FAIL %s slot_go actual %b expected %b", tag, slot_go, want);
    end
  endtask

  task automatic drive(logic [2:0] v, logic [1:0] c0, logic [1:0] c1, logic [1:0] c2,
                       int f, int ve, int g, int cq);
    @(posedge clk);
    #1;
    head_vld = v;
    head_cls = {c2, c1, c0};
    fp_free  = 4'(f);
    vec_free = 4'(ve);
    gen_free = 4'(g);
    cq_free  = 5'(cq);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    head_vld = '0; head_cls = '0;
    fp_free = '0; vec_free = '0; gen_free = '0; cq_free = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset idle");
    expect_go("R1 reset idle", 3'b000);
    rst_n = 1'b1;

    drive(3'b111, 2'd3, 2'd3, 2'd3, 8, 8, 8, 16); compare("R6 three general");  expect_go("R6", 3'b111);
    drive(3'b111, 2'd3, 2'd3, 2'd3, 8, 8, 2, 16); compare("R7 general space");  expect_go("R7", 3'b011);
    drive(3'b111, 2'd1, 2'd1, 2'd3, 8, 8, 8, 16); compare("R4 fp limit");       expect_go("R4", 3'b001);
    drive(3'b111, 2'd2, 2'd2, 2'd2, 8, 8, 8, 16); compare("R5 vec limit");      expect_go("R5", 3'b011);
    drive(3'b111, 2'd2, 2'd3, 2'd2, 8, 1, 8, 16); compare("R7 vec space");      expect_go("R7", 3'b011);
    drive(3'b101, 2'd3, 2'd3, 2'd3, 8, 8, 8, 16); compare("R3 invalid slot");   expect_go("R3", 3'b001);
    drive(3'b110, 2'd3, 2'd3, 2'd3, 8, 8, 8, 16); compare("R3 invalid head");   expect_go("R3", 3'b000);
    drive(3'b111, 2'd0, 2'd0, 2'd0, 0, 0, 0, 2);  compare("R8 cq no-queue");    expect_go("R8", 3'b011);
    drive(3'b111, 2'd3, 2'd3, 2'd3, 8, 8, 8, 0);  compare("R8 cq empty");       expect_go("R8", 3'b000);
    drive(3'b111, 2'd1, 2'd3, 2'd2, 0, 8, 8, 16); compare("R2 head blocked");   expect_go("R2", 3'b000);
    drive(3'b111, 2'd2, 2'd3, 2'd2, 8, 8, 8, 16); compare("R9 vec gen vec");    expect_go("R9", 3'b111);
    drive(3'b111, 2'd3, 2'd0, 2'd1, 8, 8, 8, 16); compare("R9 gen none fp");    expect_go("R9", 3'b111);
    drive(3'b111, 2'd3, 2'd3, 2'd3, 15, 15, 15, 31); compare("R1 max free");    expect_go("R1", 3'b111);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] v;
      v[0] = ($urandom_range(0, 9) != 0);
      v[1] = ($urandom_range(0, 9) != 0);
      v[2] = ($urandom_range(0, 9) != 0);
      if (n % 5 == 0)
        drive(v, 2'($urandom), 2'($urandom), 2'($urandom),
              $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 31));
      else
        drive(v, 2'($urandom), 2'($urandom), 2'($urandom),
              $urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 4));
      compare("random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule